// File: doc/BRIEF.md
# NAND Flash Host Bridge

This block sits between a 32-bit register-style host bus and the byte-wide bus of a NAND flash array. Software drives the flash through a small set of registers. A write to the command port produces one byte cycle with the command latch enable high. A write to the address port produces one byte cycle with the address latch enable high. A read or write of the data port moves a whole 32-bit word as four back-to-back byte cycles, most significant byte first. The host request is held until every byte cycle of the access has finished, so software never has to poll for completion of a single register access.

A control register picks which of the chip enables is driven low. It can also release all of them, and it can fire a one-cycle clear strobe toward a separate ECC accumulator. A status register reports the ready line of the device that is currently selected. Each bank has its own timing register, which sets how many clocks the write or read strobe stays low, so devices of different speed can share the bus.

Register offsets: control 0x00, command 0x04, address 0x08, data 0x0C, status 0x10, bank n timing at 0x20 + 4·n.

Top module: `nand_host_bridge`

## Requirements
- R1: A host write to offset 0x04 makes exactly one write-strobe byte cycle that carries host bits [7:0], with the command latch enable high and the address latch enable low during it. Bits [31:8] are ignored.
- R2: A host write to offset 0x08 makes exactly one write-strobe byte cycle that carries host bits [7:0], with the address latch enable high and the command latch enable low.
- R3: A host write to offset 0x0C makes four write-strobe byte cycles with both latch enables low, carrying bits [31:24], [23:16], [15:8] and [7:0] in that order.
- R4: A host read of offset 0x0C makes four read-strobe byte cycles with the data output enable low. The first byte read lands in bits [31:24] of the returned word and the last in bits [7:0].
- R5: In every byte cycle the active strobe stays low for L clocks and is then high for exactly one clock. L is bits [3:0] of the selected bank's timing register, and a value of 0 counts as 1. The host acknowledge comes 4·(L+1)+1 clocks after a data request is accepted, L+2 clocks after a command or address request, and 1 clock after a register access.
- R6: Writing the control register with bit 4 clear selects bank bits [1:0] and drives only that bank's chip enable low.
- R7: Writing the control register with bit 4 set drives all chip enables high. Bit 4 reads back as 0, and bits [1:0] read back as written.
- R8: Writing the control register with bit 5 set produces exactly one single-clock pulse on the ECC clear output. Bit 5 reads back as 0.
- R9: Reading offset 0x10 returns in bit 0 the ready input of the selected bank, where 1 means ready, and 0 in all other bits.
- R10: The timing register for bank n is at 0x20 + 4·n. Bits [3:0] are read/write and the other bits read 0. The reset value is 2, and a write to one bank leaves the other banks unchanged.
- R11: The two strobes are never low together, the two latch enables are never high together, and the data output enable is never high while the read strobe is low.
- R12: Out of reset all chip enables and both strobes are high, both latch enables, the data output enable and the acknowledge are low, and bank 0 is selected.
- R13: Each accepted host request receives a single-clock acknowledge, and the acknowledge never coincides with a low strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_ack | output | 1 | Single-clock completion pulse |
| fl_ce_n | output | NUM_BANKS | Active-low chip enables |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_re_n | output | 1 | Active-low read strobe |
| fl_dq_out | output | 8 | Flash data driven by the bridge |
| fl_dq_oe | output | 1 | Output enable for fl_dq_out |
| fl_dq_in | input | 8 | Flash data driven by the device |
| fl_rdy | input | NUM_BANKS | Per-bank ready line, 1 = ready |
| ecc_clr | output | 1 | Clear strobe to the ECC accumulator |

## Verification
The bench keeps the default parameters, four banks with a 4-bit pulse field. At that size every bank can be combined with every pulse value from 0 to 15 for data writes, every pattern of the four ready lines can be read through each bank selection, and all 256 command and address byte values can be swept. The small pulse field also brings the zero-width corner and the maximum width within a few hundred clocks per access.

// File: rtl/nhb_pkg.sv
package nhb_pkg;

    localparam int unsigned HOST_AW = 8;

    localparam logic [HOST_AW-1:0] OFS_CTRL  = 8'h00;
    localparam logic [HOST_AW-1:0] OFS_CMD   = 8'h04;
    localparam logic [HOST_AW-1:0] OFS_ADDR  = 8'h08;
    localparam logic [HOST_AW-1:0] OFS_DATA  = 8'h0C;
    localparam logic [HOST_AW-1:0] OFS_STAT  = 8'h10;
    localparam logic [HOST_AW-1:0] OFS_BANK0 = 8'h20;

    localparam int unsigned CTRL_CEOFF_BIT = 4;
    localparam int unsigned CTRL_ECC_BIT   = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CMD,
        SEL_ADDR,
        SEL_DATA,
        SEL_STAT,
        SEL_BANK
    } reg_sel_e;

    typedef enum logic [1:0] {
        XK_CMD,
        XK_ADDR,
        XK_WDATA,
        XK_RDATA
    } xfer_kind_e;

    typedef enum logic [1:0] {
        E_IDLE,
        E_LOW,
        E_HIGH
    } eng_st_e;

    typedef enum logic [1:0] {
        H_IDLE,
        H_WAIT,
        H_ACK
    } host_st_e;

    typedef struct packed {
        xfer_kind_e  kind;
        logic [31:0] word;
    } xfer_req_t;

    function automatic reg_sel_e decode_sel(input logic [HOST_AW-1:0] ofs,
                                            input int unsigned nbanks);
        if (ofs == OFS_CTRL) return SEL_CTRL;
        if (ofs == OFS_CMD)  return SEL_CMD;
        if (ofs == OFS_ADDR) return SEL_ADDR;
        if (ofs == OFS_DATA) return SEL_DATA;
        if (ofs == OFS_STAT) return SEL_STAT;
        if ((int'(ofs) >= int'(OFS_BANK0)) &&
            (int'(ofs) < int'(OFS_BANK0) + 4 * int'(nbanks)) &&
            (ofs[1:0] == 2'b00))
            return SEL_BANK;
        return SEL_NONE;
    endfunction

    function automatic logic is_burst(input xfer_kind_e k);
        return (k == XK_WDATA) || (k == XK_RDATA);
    endfunction

endpackage

// File: rtl/nhb_regfile.sv
module nhb_regfile
    import nhb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int PULSE_W   = 4,
    parameter int DEF_PULSE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ctrl,
    input  logic               wr_bank,
    input  logic [BANK_W-1:0]  bank_idx,
    input  logic [31:0]        wdata,
    output logic [BANK_W-1:0]  bank_sel,
    output logic               ce_on,
    output logic               ecc_clr,
    output logic [PULSE_W-1:0] cfg_rd,
    output logic [PULSE_W-1:0] sel_pulse
);

    logic [PULSE_W-1:0] cfg_q [NUM_BANKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_sel <= '0;
            ce_on    <= 1'b0;
            ecc_clr  <= 1'b0;
        end else begin
            ecc_clr <= wr_ctrl && wdata[CTRL_ECC_BIT];
            if (wr_ctrl) begin
                bank_sel <= wdata[BANK_W-1:0];
                ce_on    <= !wdata[CTRL_CEOFF_BIT];
            end
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[g] <= PULSE_W'(DEF_PULSE);
            else if (wr_bank && (bank_idx == BANK_W'(g)))
                cfg_q[g] <= wdata[PULSE_W-1:0];
        end
    end

    always_comb begin
        cfg_rd    = '0;
        sel_pulse = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_idx == BANK_W'(i)) cfg_rd    = cfg_q[i];
            if (bank_sel == BANK_W'(i)) sel_pulse = cfg_q[i];
        end
    end

endmodule

// File: rtl/nhb_byte_engine.sv
module nhb_byte_engine
    import nhb_pkg::*;
#(
    parameter int PULSE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  xfer_req_t          req,
    input  logic [PULSE_W-1:0] pulse,
    input  logic [7:0]         fl_dq_in,
    output logic               done,
    output logic [31:0]        rdata,
    output logic [7:0]         fl_dq_out,
    output logic               fl_dq_oe,
    output logic               fl_cle,
    output logic               fl_ale,
    output logic               fl_we_n,
    output logic               fl_re_n
);

    eng_st_e            st;
    xfer_kind_e         kind_q;
    logic [PULSE_W-1:0] cnt;
    logic [PULSE_W-1:0] len_m1;
    logic [1:0]         left;
    logic [31:0]        tx_sh;
    logic [31:0]        rx_sh;
    logic [PULSE_W-1:0] eff_m1;
    logic               rd;
    logic               active;

    always_comb begin
        eff_m1 = (pulse == '0) ? '0 : pulse - PULSE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= E_IDLE;
            kind_q <= XK_CMD;
            cnt    <= '0;
            len_m1 <= '0;
            left   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else begin
            unique case (st)
                E_IDLE: begin
                    if (start) begin
                        st     <= E_LOW;
                        kind_q <= req.kind;
                        cnt    <= eff_m1;
                        len_m1 <= eff_m1;
                        left   <= is_burst(req.kind) ? 2'd3 : 2'd0;
                        tx_sh  <= is_burst(req.kind) ? req.word
                                                     : {req.word[7:0], 24'h0};
                    end
                end
                E_LOW: begin
                    if (cnt == '0) begin
                        st <= E_HIGH;
                        if (kind_q == XK_RDATA)
                            rx_sh <= {rx_sh[23:0], fl_dq_in};
                    end else begin
                        cnt <= cnt - PULSE_W'(1);
                    end
                end
                E_HIGH: begin
                    if (left == 2'd0) begin
                        st <= E_IDLE;
                    end else begin
                        left  <= left - 2'd1;
                        tx_sh <= {tx_sh[23:0], 8'h00};
                        cnt   <= len_m1;
                        st    <= E_LOW;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        rd        = (kind_q == XK_RDATA);
        active    = (st != E_IDLE);
        fl_we_n   = !((st == E_LOW) && !rd);
        fl_re_n   = !((st == E_LOW) && rd);
        fl_cle    = active && (kind_q == XK_CMD);
        fl_ale    = active && (kind_q == XK_ADDR);
        fl_dq_oe  = active && !rd;
        fl_dq_out = tx_sh[31:24];
        done      = (st == E_HIGH) && (left == 2'd0);
        rdata     = rx_sh;
    end

endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
    import nhb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int PULSE_W   = 4,
    parameter int DEF_PULSE = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [7:0]           host_addr,
    input  logic [31:0]          host_wdata,
    output logic [31:0]          host_rdata,
    output logic                 host_ack,
    output logic [NUM_BANKS-1:0] fl_ce_n,
    output logic                 fl_cle,
    output logic                 fl_ale,
    output logic                 fl_we_n,
    output logic                 fl_re_n,
    output logic [7:0]           fl_dq_out,
    output logic                 fl_dq_oe,
    input  logic [7:0]           fl_dq_in,
    input  logic [NUM_BANKS-1:0] fl_rdy,
    output logic                 ecc_clr
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    host_st_e           hst;
    reg_sel_e           sel;
    logic               go;
    logic               is_flash;
    logic               eng_start;
    logic               eng_done;
    logic [31:0]        eng_rdata;
    xfer_req_t          xreq;
    logic               wr_ctrl;
    logic               wr_bank;
    logic [BANK_W-1:0]  bank_idx;
    logic [7:0]         bank_ofs;
    logic [BANK_W-1:0]  bank_sel;
    logic               ce_on;
    logic [PULSE_W-1:0] cfg_rd;
    logic [PULSE_W-1:0] sel_pulse;
    logic               rdy_sel;
    logic [31:0]        rb;
    logic [31:0]        rdata_q;

    always_comb begin
        sel      = decode_sel(host_addr, NUM_BANKS);
        go       = (hst == H_IDLE) && host_req;
        is_flash = host_we ? ((sel == SEL_CMD) || (sel == SEL_ADDR) || (sel == SEL_DATA))
                           : (sel == SEL_DATA);
        eng_start = go && is_flash;
        wr_ctrl   = go && host_we && (sel == SEL_CTRL);
        wr_bank   = go && host_we && (sel == SEL_BANK);
        bank_ofs  = host_addr - OFS_BANK0;
        bank_idx  = bank_ofs[BANK_W+1:2];

        xreq.word = host_wdata;
        unique case (sel)
            SEL_CMD:  xreq.kind = XK_CMD;
            SEL_ADDR: xreq.kind = XK_ADDR;
            default:  xreq.kind = host_we ? XK_WDATA : XK_RDATA;
        endcase

        rdy_sel = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++)
            if (bank_sel == BANK_W'(i)) rdy_sel = fl_rdy[i];

        unique case (sel)
            SEL_CTRL: rb = 32'(bank_sel);
            SEL_STAT: rb = {31'h0, rdy_sel};
            SEL_BANK: rb = 32'(cfg_rd);
            default:  rb = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hst     <= H_IDLE;
            rdata_q <= '0;
        end else begin
            unique case (hst)
                H_IDLE: begin
                    if (go) begin
                        if (is_flash) begin
                            hst <= H_WAIT;
                        end else begin
                            hst     <= H_ACK;
                            rdata_q <= rb;
                        end
                    end
                end
                H_WAIT: begin
                    if (eng_done) begin
                        hst     <= H_ACK;
                        rdata_q <= eng_rdata;
                    end
                end
                H_ACK:   hst <= H_IDLE;
                default: hst <= H_IDLE;
            endcase
        end
    end

    assign host_ack   = (hst == H_ACK);
    assign host_rdata = rdata_q;

    nhb_regfile #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .PULSE_W   (PULSE_W),
        .DEF_PULSE (DEF_PULSE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wr_bank   (wr_bank),
        .bank_idx  (bank_idx),
        .wdata     (host_wdata),
        .bank_sel  (bank_sel),
        .ce_on     (ce_on),
        .ecc_clr   (ecc_clr),
        .cfg_rd    (cfg_rd),
        .sel_pulse (sel_pulse)
    );

    nhb_byte_engine #(
        .PULSE_W (PULSE_W)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (eng_start),
        .req       (xreq),
        .pulse     (sel_pulse),
        .fl_dq_in  (fl_dq_in),
        .done      (eng_done),
        .rdata     (eng_rdata),
        .fl_dq_out (fl_dq_out),
        .fl_dq_oe  (fl_dq_oe),
        .fl_cle    (fl_cle),
        .fl_ale    (fl_ale),
        .fl_we_n   (fl_we_n),
        .fl_re_n   (fl_re_n)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_ce
        assign fl_ce_n[g] = !(ce_on && (bank_sel == BANK_W'(g)));
    end

endmodule

// File: rtl/nhb_checker.sv
module nhb_checker
    import nhb_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 host_we,
    input logic [7:0]           host_addr,
    input logic [31:0]          host_wdata,
    input logic                 host_ack,
    input logic [NUM_BANKS-1:0] fl_ce_n,
    input logic                 fl_cle,
    input logic                 fl_ale,
    input logic                 fl_we_n,
    input logic                 fl_re_n,
    input logic                 fl_dq_oe,
    input logic                 ecc_clr
);

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_re_n));

    assert_latch_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(fl_cle && fl_ale));

    assert_no_drive_on_read_R11: assert property (@(posedge clk) disable iff (rst)
        !fl_re_n |-> !fl_dq_oe);

    assert_cmd_driven_R1: assert property (@(posedge clk) disable iff (rst)
        fl_cle |-> fl_dq_oe);

    assert_ce_single_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(~fl_ce_n) <= 1);

    assert_ce_select_R6: assert property (@(posedge clk) disable iff (rst)
        (host_ack && host_we && host_addr == OFS_CTRL &&
         !host_wdata[CTRL_CEOFF_BIT] && int'(host_wdata[7:0]) < NUM_BANKS)
        |-> ($countones(~fl_ce_n) == 1));

    assert_ce_release_R7: assert property (@(posedge clk) disable iff (rst)
        (host_ack && host_we && host_addr == OFS_CTRL && host_wdata[CTRL_CEOFF_BIT])
        |-> (&fl_ce_n));

    assert_ecc_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        ecc_clr |=> !ecc_clr);

    assert_ack_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    assert_ack_idle_bus_R13: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> (fl_we_n && fl_re_n));

endmodule

bind nand_host_bridge nhb_checker #(.NUM_BANKS(NUM_BANKS)) u_nhb_checker (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_ack   (host_ack),
    .fl_ce_n    (fl_ce_n),
    .fl_cle     (fl_cle),
    .fl_ale     (fl_ale),
    .fl_we_n    (fl_we_n),
    .fl_re_n    (fl_re_n),
    .fl_dq_oe   (fl_dq_oe),
    .ecc_clr    (ecc_clr)
);

// File: tb/test_nand_host_bridge.sv
module test_nand_host_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_CMD  = 8'h04;
    localparam logic [7:0] A_ADDR = 8'h08;
    localparam logic [7:0] A_DATA = 8'h0C;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_BNK  = 8'h20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [7:0]    host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          host_ack;
    logic [NB-1:0] fl_ce_n;
    logic          fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe, ecc_clr;
    logic [7:0]    fl_dq_out;
    logic [7:0]    fl_dq_in;
    logic [NB-1:0] fl_rdy = '1;

    int total = 0;
    int bad = 0;

    // flash bus monitor log
    logic [7:0]    m_byte [16];
    logic          m_cle [16];
    logic          m_ale [16];
    logic          m_rd [16];
    logic [NB-1:0] m_ce [16];
    int            m_low [16];
    int            m_gap [16];
    int            m_n = 0;
    int            low_cnt = 0;
    int            gap_cnt = 0;
    int            rd_ptr = 0;
    int            ecc_cnt = 0;
    logic [7:0]    c_byte;
    logic          c_cle, c_ale, c_rd;
    logic [NB-1:0] c_ce;
    int            c_gap;

    function automatic logic [7:0] pat(input int p);
        return 8'(p * 29 + 55);
    endfunction

    assign fl_dq_in = pat(rd_ptr);

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_host_bridge i_nand_host_bridge (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_ack   (host_ack),
        .fl_ce_n    (fl_ce_n),
        .fl_cle     (fl_cle),
        .fl_ale     (fl_ale),
        .fl_we_n    (fl_we_n),
        .fl_re_n    (fl_re_n),
        .fl_dq_out  (fl_dq_out),
        .fl_dq_oe   (fl_dq_oe),
        .fl_dq_in   (fl_dq_in),
        .fl_rdy     (fl_rdy),
        .ecc_clr    (ecc_clr)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ecc_clr) ecc_cnt++;
            if (!fl_we_n || !fl_re_n) begin
                if (low_cnt == 0) c_gap = gap_cnt;
                low_cnt++;
                c_byte  = fl_dq_out;
                c_cle   = fl_cle;
                c_ale   = fl_ale;
                c_rd    = !fl_re_n;
                c_ce    = fl_ce_n;
                gap_cnt = 0;
            end else begin
                if (low_cnt != 0) begin
                    if (m_n < 16) begin
                        m_byte[m_n] = c_byte;
                        m_cle[m_n]  = c_cle;
                        m_ale[m_n]  = c_ale;
                        m_rd[m_n]   = c_rd;
                        m_ce[m_n]   = c_ce;
                        m_low[m_n]  = low_cnt;
                        m_gap[m_n]  = c_gap;
                    end
                    m_n++;
                    if (c_rd) rd_ptr++;
                    low_cnt = 0;
                end
                gap_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] r, output int lat);
        @(negedge clk);
        m_n        = 0;
        host_req   = 1'b1;
        host_we    = w;
        host_addr  = a;
        host_wdata = d;
        lat        = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_ack);
        r        = host_rdata;
        host_req = 1'b0;
        host_we  = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r, d, e;
        int lat, eff, p0, e0;
        bit ok;

        repeat (4) @(negedge clk);
        // R12 reset values while and after reset
        chk(fl_ce_n == '1 && fl_we_n && fl_re_n && !fl_cle && !fl_ale && !fl_dq_oe &&
            !host_ack, "R12 reset outputs", {fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale},
            {4'hF, 4'hC});
        rst = 1'b0;
        @(negedge clk);
        chk(fl_ce_n == '1 && fl_we_n && fl_re_n && !ecc_clr, "R12 after reset",
            {28'h0, fl_ce_n}, 32'hF);
        bus(1'b0, A_CTRL, 0, r, lat);
        chk(r == 0, "R12 bank 0 selected", r, 0);

        // R10 reset value and per-bank storage
        for (int b = 0; b < NB; b++) begin
            bus(1'b0, A_BNK + 8'(4 * b), 0, r, lat);
            chk(r == 2, "R10 reset timing", r, 2);
        end
        for (int b = 0; b < NB; b++)
            bus(1'b1, A_BNK + 8'(4 * b), 32'hFFFF_FFF0 | 32'(b + 5), r, lat);
        for (int b = 0; b < NB; b++) begin
            bus(1'b0, A_BNK + 8'(4 * b), 0, r, lat);
            chk(r == 32'(b + 5), "R10 bank readback", r, 32'(b + 5));
            chk(lat == 1, "R5 register ack latency", lat, 1);
        end

        // R6/R7/R8 control register
        for (int b = 0; b < NB; b++) begin
            bus(1'b1, A_CTRL, 32'(b), r, lat);
            chk(fl_ce_n == ~(NB'(1) << b), "R6 chip enable select", {28'h0, fl_ce_n},
                {28'h0, ~(NB'(1) << b)});
            bus(1'b1, A_CTRL, 32'(b) | 32'h10, r, lat);
            chk(fl_ce_n == '1, "R7 all chip enables released", {28'h0, fl_ce_n}, 32'hF);
            bus(1'b0, A_CTRL, 0, r, lat);
            chk(r == 32'(b), "R7 control readback", r, 32'(b));
            e0 = ecc_cnt;
            bus(1'b1, A_CTRL, 32'(b) | 32'h20, r, lat);
            repeat (2) @(negedge clk);
            chk(ecc_cnt == e0 + 1, "R8 ecc clear pulse", 32'(ecc_cnt - e0), 1);
            bus(1'b0, A_CTRL, 0, r, lat);
            chk(r == 32'(b), "R8 ecc bit reads 0", r, 32'(b));
        end

        // R9 status over all ready patterns
        for (int b = 0; b < NB; b++) begin
            bus(1'b1, A_CTRL, 32'(b), r, lat);
            for (int pr = 0; pr < 16; pr++) begin
                fl_rdy = NB'(pr);
                bus(1'b0, A_STAT, 0, r, lat);
                e = 32'((pr >> b) & 1);
                chk(r == e, "R9 status ready", r, e);
            end
        end
        fl_rdy = '1;

        // R1/R2 all byte values, bank 0 pulse 1
        bus(1'b1, A_BNK, 1, r, lat);
        bus(1'b1, A_CTRL, 0, r, lat);
        for (int v = 0; v < 256; v++) begin
            bus(1'b1, A_CMD, 32'hA5C3_0000 | 32'(v << 8) | 32'(v), r, lat);
            ok = m_n == 1 && m_byte[0] == 8'(v) && m_cle[0] && !m_ale[0] && !m_rd[0];
            chk(ok, "R1 command cycle", {16'h0, 8'(m_n), m_byte[0]}, {16'h0, 8'h1, 8'(v)});
            chk(lat == 3, "R5 command latency", lat, 3);
            bus(1'b1, A_ADDR, 32'h5A00_0000 | 32'(v), r, lat);
            ok = m_n == 1 && m_byte[0] == 8'(v) && !m_cle[0] && m_ale[0] && !m_rd[0];
            chk(ok, "R2 address cycle", {16'h0, 8'(m_n), m_byte[0]}, {16'h0, 8'h1, 8'(v)});
        end

        // R3/R5 data writes over every bank and pulse value
        for (int b = 0; b < NB; b++) begin
            for (int L = 0; L < 16; L++) begin
                bus(1'b1, A_BNK + 8'(4 * b), 32'(L), r, lat);
                bus(1'b1, A_CTRL, 32'(b), r, lat);
                d = 32'h1357_9BDF ^ (32'(b * 16 + L) * 32'h0101_0101);
                bus(1'b1, A_DATA, d, r, lat);
                eff = (L == 0) ? 1 : L;
                ok = (m_n == 4);
                for (int k = 0; k < 4 && k < m_n; k++)
                    ok &= m_byte[k] == d[31 - 8 * k -: 8] && !m_cle[k] && !m_ale[k] && !m_rd[k];
                chk(ok, "R3 write byte order", {m_byte[0], m_byte[1], m_byte[2], m_byte[3]}, d);
                ok = (m_n == 4) && (lat == 4 * (eff + 1) + 1);
                for (int k = 0; k < 4 && k < m_n; k++) begin
                    ok &= m_low[k] == eff;
                    if (k > 0) ok &= m_gap[k] == 1;
                end
                chk(ok, "R5 strobe width and stall", lat, 4 * (eff + 1) + 1);
                chk(m_ce[0] == ~(NB'(1) << b), "R6 chip enable during cycles",
                    {28'h0, m_ce[0]}, {28'h0, ~(NB'(1) << b)});
            end
        end

        // R4 data reads
        for (int b = 0; b < NB; b++) begin
            for (int li = 0; li < 4; li++) begin
                eff = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : 15;
                bus(1'b1, A_BNK + 8'(4 * b), 32'(eff), r, lat);
                bus(1'b1, A_CTRL, 32'(b), r, lat);
                p0 = rd_ptr;
                bus(1'b0, A_DATA, 0, r, lat);
                e = {pat(p0), pat(p0 + 1), pat(p0 + 2), pat(p0 + 3)};
                chk(r == e, "R4 read byte order", r, e);
                if (eff == 0) eff = 1;
                ok = (m_n == 4) && (lat == 4 * (eff + 1) + 1);
                for (int k = 0; k < 4 && k < m_n; k++)
                    ok &= m_rd[k] && m_low[k] == eff && !m_cle[k] && !m_ale[k];
                chk(ok, "R4 R5 read strobes", lat, 4 * (eff + 1) + 1);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule